// File: doc/BRIEF.md
# LCD Host Command Decoder and Display Memory Address Controller

This block is the host-facing control logic of a graphic LCD driver. A host processor presents a byte on an 8-bit bus together with a data/command qualifier and a read/write qualifier, then pulls a strobe low. The block synchronises the strobe and detects its falling edge. It then either decodes the byte as a command or performs one byte-wide access to a display memory of three pages by 120 columns. Commands set the page and column pointers, a saved copy of the column pointer, a contrast level, a scroll offset, a temperature-coefficient code, three annunciator enables and a vector of single-bit enables for the display and its analog support circuits. The display scan and the analog circuits are outside the block and only see these register bits.

Memory clearing works in two steps. A clear command only arms the operation. The next data write is then used up as a trigger and is neither stored nor allowed to move the column pointer. The armed pages are then zeroed one column per clock while a busy flag is high, and host transfers that arrive during that time are dropped.

Top module: `lcd_host_ctrl`

## Requirements
- R1: After a synchronous reset, page_sel, col_ptr, contrast_lvl, scroll_ofs, temp_coef, annun_on, ctrl_flags, bus_dout and busy are all zero.
- R2: A transfer is taken on the strobe's falling edge. Its result shows on the outputs right after the third rising clock edge that follows the first edge sampling bus_stb low. The pair dc=0/rw=0 is a command, dc=1/rw=0 is a memory write and dc=1/rw=1 is a memory read. The pair dc=0/rw=1 is ignored.
- R3: Command 1ccccccc loads col_ptr with ccccccc when that value is at most 119. A larger value is ignored.
- R4: A write stores the byte at address page*120+column. A read places that byte on bus_dout, which then holds until the next read. Both move col_ptr up by one, and 119 wraps to 0. page_sel does not change.
- R5: Command 000000pp with pp = 0, 1 or 2 selects that page, where page 2 is the icon row. Command 0x03 is ignored.
- R6: Command 0x35 copies col_ptr into a save register, which is reset to 0. Command 0x34 loads col_ptr from that register.
- R7: Command 0x36 arms a clear of pages 0 and 1, and 0x37 arms a clear of page 2. The last arm given wins. Reads are executed normally while a clear is armed. The next write is a dummy: it stores nothing and leaves col_ptr unchanged. It starts the clear, which keeps busy high for exactly 240 or 120 cycles and leaves those locations reading zero. The arm is used up, and other pages keep their contents.
- R8: Every transfer that would execute while busy is high is dropped and changes nothing.
- R9: Command 0001cccc loads contrast_lvl. Command 0x71 increments it and 0x70 decrements it, both modulo 16.
- R10: Each ctrl_flags bit is cleared by an even code and set by the next odd code. The pairs are 0x20 (bit 0), 0x22 (bit 1), 0x24 (bit 2), 0x28 (bit 3), 0x2A (bit 4), 0x2C (bit 5), 0x2E (bit 6), 0x30 (bit 7), 0x32 (bit 8), 0x3C (bit 9), 0x3E (bit 10), 0x7A (bit 11) and 0x7E (bit 12).
- R11: Command 0100ssss loads scroll_ofs with ssss. Command 011011tt loads temp_coef with tt.
- R12: Command 01100aab with aa = 0, 1 or 2 writes b into annun_on[aa]. The value aa = 3 (0x66, 0x67) is ignored.
- R13: Reserved command codes change nothing. These are 0x26, 0x27, 0x38 to 0x3B, 0x50 to 0x5F, 0x68 to 0x6B, 0x72 to 0x79, 0x7C and 0x7D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb | input | 1 | Host strobe, idle high, transfer taken on its falling edge |
| bus_dc | input | 1 | 1 = memory access, 0 = command |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_din | input | 8 | Host byte |
| bus_dout | output | 8 | Registered read data |
| busy | output | 1 | High while a clear walks the memory |
| page_sel | output | 2 | Current page pointer |
| col_ptr | output | 7 | Current column pointer |
| contrast_lvl | output | 4 | Contrast level |
| scroll_ofs | output | 4 | Vertical scroll offset |
| temp_coef | output | 2 | Temperature-coefficient code |
| annun_on | output | 3 | Annunciator enables |
| ctrl_flags | output | 13 | Single-bit enables, positions as in R10 |

## Verification
Writes that hit ascending columns and the last column show whether the pointer increments and wraps correctly. Reads of those same addresses show whether page and column are combined into the right address. Clear sequences are run with data already in all three pages, with a read placed between the arm and the dummy write, and with a command sent while busy is high. These runs separate which pages a clear touches, whether reads disturb the arm, and whether transfers during busy are really dropped. Every command code group is swept, including out-of-range columns, page 3, annunciator index 3 and the reserved codes, so that decode gaps cannot hide behind neighbouring codes.

// File: rtl/lcdh_pkg.sv
package lcdh_pkg;
  localparam int NFLAGS = 13;
  localparam int ARGW   = 7;

  typedef enum logic [3:0] {
    OP_NONE, OP_COL, OP_PAGE, OP_CTR_LD, OP_CTR_INC, OP_CTR_DEC,
    OP_FLAG, OP_SCROLL, OP_TCOEF, OP_ANNUN, OP_SAVE, OP_RESTORE,
    OP_ARM_MAIN, OP_ARM_ICON, OP_WRITE, OP_READ
  } op_e;

  typedef enum logic [1:0] {ARM_NONE, ARM_MAIN, ARM_ICON} arm_e;
endpackage

// File: rtl/lcdh_strobe_cap.sv
module lcdh_strobe_cap #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stb,
  input  logic       dc,
  input  logic       rw,
  input  logic [7:0] din,
  output logic       vld,
  output logic       dc_q,
  output logic       rw_q,
  output logic [7:0] din_q
);
  logic [SYNC_STAGES:0] sh;
  logic fall;

  // strobe synchroniser, idle level high
  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[SYNC_STAGES-1:0], stb};
  end

  assign fall = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];

  // R2: one-cycle transfer pulse with the bus captured beside it
  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= 1'b0;
      dc_q  <= 1'b0;
      rw_q  <= 1'b0;
      din_q <= '0;
    end else begin
      vld <= fall;
      if (fall) begin
        dc_q  <= dc;
        rw_q  <= rw;
        din_q <= din;
      end
    end
  end
endmodule

// File: rtl/lcdh_cmd_decode.sv
module lcdh_cmd_decode
  import lcdh_pkg::*;
#(
  parameter int COLS = 120
) (
  input  logic            dc,
  input  logic            rw,
  input  logic [7:0]      b,
  output op_e             op,
  output logic [ARGW-1:0] arg
);
  localparam logic [6:0] COL_LIM = 7'(COLS);

  always_comb begin
    op  = OP_NONE;
    arg = '0;
    if (dc) begin
      op  = rw ? OP_READ : OP_WRITE;          // R4
    end else if (!rw) begin                   // R2: dc=0, rw=1 stays OP_NONE
      if (b[7]) begin
        if (b[6:0] < COL_LIM) begin           // R3
          op  = OP_COL;
          arg = b[6:0];
        end
      end else begin
        casez (b[6:0])
          7'b00000??: if (b[1:0] != 2'b11) begin   // R5
            op  = OP_PAGE;
            arg = {5'b0, b[1:0]};
          end
          7'b001????: begin                   // R9
            op  = OP_CTR_LD;
            arg = {3'b0, b[3:0]};
          end
          7'b010????: if (b[3:1] != 3'b011) begin  // R10, R13
            op  = OP_FLAG;
            arg = {3'b0, (b[3:1] < 3'd3) ? b[3:1] : b[3:1] - 3'd1, b[0]};
          end
          7'b011????: begin
            case (b[3:1])
              3'b000: begin op = OP_FLAG; arg = {2'b0, 4'd7,  b[0]}; end
              3'b001: begin op = OP_FLAG; arg = {2'b0, 4'd8,  b[0]}; end
              3'b010: op = b[0] ? OP_SAVE : OP_RESTORE;        // R6
              3'b011: op = b[0] ? OP_ARM_ICON : OP_ARM_MAIN;   // R7
              3'b110: begin op = OP_FLAG; arg = {2'b0, 4'd9,  b[0]}; end
              3'b111: begin op = OP_FLAG; arg = {2'b0, 4'd10, b[0]}; end
              default: op = OP_NONE;                           // R13
            endcase
          end
          7'b100????: begin                   // R11
            op  = OP_SCROLL;
            arg = {3'b0, b[3:0]};
          end
          7'b1100???: if (b[2:1] != 2'b11) begin   // R12
            op  = OP_ANNUN;
            arg = {4'b0, b[2:0]};
          end
          7'b11011??: begin                   // R11
            op  = OP_TCOEF;
            arg = {5'b0, b[1:0]};
          end
          7'b111000?: op = b[0] ? OP_CTR_INC : OP_CTR_DEC;
          7'b111101?: begin op = OP_FLAG; arg = {2'b0, 4'd11, b[0]}; end
          7'b111111?: begin op = OP_FLAG; arg = {2'b0, 4'd12, b[0]}; end
          default: op = OP_NONE;              // R13
        endcase
      end
    end
  end
endmodule

// File: rtl/lcdh_cfg_regs.sv
module lcdh_cfg_regs
  import lcdh_pkg::*;
#(
  parameter int NANN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec,
  input  op_e               op,
  input  logic [4:0]        arg,
  output logic [3:0]        contrast,
  output logic [3:0]        scroll,
  output logic [1:0]        tcoef,
  output logic [NANN-1:0]   annun,
  output logic [NFLAGS-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      contrast <= '0;
      scroll   <= '0;
      tcoef    <= '0;
    end else if (exec) begin
      case (op)
        OP_CTR_LD:  contrast <= arg[3:0];            // R9
        OP_CTR_INC: contrast <= contrast + 4'd1;
        OP_CTR_DEC: contrast <= contrast - 4'd1;
        OP_SCROLL:  scroll   <= arg[3:0];            // R11
        OP_TCOEF:   tcoef    <= arg[1:0];
        default: ;
      endcase
    end
  end

  // R10: one register per enable bit
  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else if (exec && op == OP_FLAG && arg[4:1] == 4'(i)) flags[i] <= arg[0];
    end
  end

  // R12: one register per annunciator
  for (genvar j = 0; j < NANN; j++) begin : g_ann
    always_ff @(posedge clk) begin
      if (rst) annun[j] <= 1'b0;
      else if (exec && op == OP_ANNUN && arg[2:1] == 2'(j)) annun[j] <= arg[0];
    end
  end
endmodule

// File: rtl/lcdh_addr_ctrl.sv
module lcdh_addr_ctrl
  import lcdh_pkg::*;
#(
  parameter int COLS       = 120,
  parameter int PAGES      = 3,
  parameter int MAIN_PAGES = 2,
  parameter int CW         = $clog2(COLS),
  parameter int PW         = $clog2(PAGES),
  parameter int AW         = $clog2(PAGES*COLS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exec,
  input  op_e             op,
  input  logic [ARGW-1:0] arg,
  input  logic [7:0]      din,
  output logic [PW-1:0]   page,
  output logic [CW-1:0]   col,
  output logic            busy,
  output logic            mem_we,
  output logic [AW-1:0]   mem_waddr,
  output logic [7:0]      mem_wdata,
  output logic            mem_re,
  output logic [AW-1:0]   mem_raddr
);
  localparam logic [CW-1:0] COL_LAST  = CW'(COLS-1);
  localparam logic [AW-1:0] MAIN_END  = AW'(MAIN_PAGES*COLS-1);
  localparam logic [AW-1:0] ICON_BASE = AW'(MAIN_PAGES*COLS);
  localparam logic [AW-1:0] ALL_END   = AW'(PAGES*COLS-1);

  logic [CW-1:0] save_q;
  arm_e          arm_q;
  logic          clr_run;
  logic [AW-1:0] clr_addr, clr_last;
  logic [AW-1:0] host_addr;
  logic [CW-1:0] col_inc;

  assign host_addr = AW'(page) * AW'(COLS) + AW'(col);
  assign col_inc   = (col == COL_LAST) ? '0 : col + 1'b1;   // R4 wrap

  always_ff @(posedge clk) begin
    if (rst) begin
      page     <= '0;
      col      <= '0;
      save_q   <= '0;
      arm_q    <= ARM_NONE;
      clr_run  <= 1'b0;
      clr_addr <= '0;
      clr_last <= '0;
    end else begin
      if (clr_run) begin
        clr_addr <= clr_addr + 1'b1;
        if (clr_addr == clr_last) clr_run <= 1'b0;
      end
      if (exec) begin
        case (op)
          OP_COL:      col    <= arg[CW-1:0];          // R3
          OP_PAGE:     page   <= arg[PW-1:0];          // R5
          OP_SAVE:     save_q <= col;                  // R6
          OP_RESTORE:  col    <= save_q;
          OP_ARM_MAIN: arm_q  <= ARM_MAIN;             // R7
          OP_ARM_ICON: arm_q  <= ARM_ICON;
          OP_WRITE: begin
            if (arm_q != ARM_NONE) begin               // R7 dummy write
              clr_run  <= 1'b1;
              arm_q    <= ARM_NONE;
              clr_addr <= (arm_q == ARM_MAIN) ? '0 : ICON_BASE;
              clr_last <= (arm_q == ARM_MAIN) ? MAIN_END : ALL_END;
            end else begin
              col <= col_inc;
            end
          end
          OP_READ:     col <= col_inc;
          default: ;
        endcase
      end
    end
  end

  assign busy      = clr_run;
  assign mem_we    = clr_run | (exec && op == OP_WRITE && arm_q == ARM_NONE);
  assign mem_waddr = clr_run ? clr_addr : host_addr;
  assign mem_wdata = clr_run ? 8'h00 : din;
  assign mem_re    = exec && op == OP_READ;
  assign mem_raddr = host_addr;
endmodule

// File: rtl/lcdh_disp_ram.sv
module lcdh_disp_ram #(
  parameter int DEPTH = 360,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port, held between reads (R4)
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lcd_host_ctrl.sv
module lcd_host_ctrl
  import lcdh_pkg::*;
#(
  parameter int COLS        = 120,
  parameter int PAGES       = 3,
  parameter int MAIN_PAGES  = 2,
  parameter int SYNC_STAGES = 2,
  parameter int NANN        = 3,
  parameter int CW          = $clog2(COLS),
  parameter int PW          = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_stb,
  input  logic              bus_dc,
  input  logic              bus_rw,
  input  logic [7:0]        bus_din,
  output logic [7:0]        bus_dout,
  output logic              busy,
  output logic [PW-1:0]     page_sel,
  output logic [CW-1:0]     col_ptr,
  output logic [3:0]        contrast_lvl,
  output logic [3:0]        scroll_ofs,
  output logic [1:0]        temp_coef,
  output logic [NANN-1:0]   annun_on,
  output logic [NFLAGS-1:0] ctrl_flags
);
  localparam int DEPTH = PAGES * COLS;
  localparam int AW    = $clog2(DEPTH);

  logic            cap_vld, cap_dc, cap_rw;
  logic [7:0]      cap_din;
  op_e             op;
  logic [ARGW-1:0] arg;
  logic            exec;
  logic            mem_we, mem_re;
  logic [AW-1:0]   mem_waddr, mem_raddr;
  logic [7:0]      mem_wdata;

  lcdh_strobe_cap #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst(rst), .stb(bus_stb), .dc(bus_dc), .rw(bus_rw), .din(bus_din),
    .vld(cap_vld), .dc_q(cap_dc), .rw_q(cap_rw), .din_q(cap_din)
  );

  lcdh_cmd_decode #(.COLS(COLS)) u_dec (
    .dc(cap_dc), .rw(cap_rw), .b(cap_din), .op(op), .arg(arg)
  );

  // R8: nothing executes while the clear walker owns the memory
  assign exec = cap_vld & ~busy;

  lcdh_cfg_regs #(.NANN(NANN)) u_cfg (
    .clk(clk), .rst(rst), .exec(exec), .op(op), .arg(arg[4:0]),
    .contrast(contrast_lvl), .scroll(scroll_ofs), .tcoef(temp_coef),
    .annun(annun_on), .flags(ctrl_flags)
  );

  lcdh_addr_ctrl #(.COLS(COLS), .PAGES(PAGES), .MAIN_PAGES(MAIN_PAGES),
                   .CW(CW), .PW(PW), .AW(AW)) u_addr (
    .clk(clk), .rst(rst), .exec(exec), .op(op), .arg(arg), .din(cap_din),
    .page(page_sel), .col(col_ptr), .busy(busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr)
  );

  lcdh_disp_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(bus_dout)
  );
endmodule

// File: rtl/lcd_host_ctrl_chk.sv
module lcd_host_ctrl_chk #(
  parameter int COLS       = 120,
  parameter int PAGES      = 3,
  parameter int MAIN_PAGES = 2,
  parameter int CW         = 7,
  parameter int PW         = 2,
  parameter int NFLAGS     = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              mem_re,
  input logic [7:0]        bus_dout,
  input logic [PW-1:0]     page_sel,
  input logic [CW-1:0]     col_ptr,
  input logic [3:0]        contrast_lvl,
  input logic [NFLAGS-1:0] ctrl_flags
);
  int run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  p_col_range_r3: assert property (@(posedge clk) disable iff (rst)
    int'(col_ptr) < COLS);

  p_page_range_r5: assert property (@(posedge clk) disable iff (rst)
    int'(page_sel) < PAGES);

  p_dout_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_re |=> $stable(bus_dout));

  p_dummy_no_inc_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $stable(col_ptr));

  p_busy_len_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == COLS || run_len == MAIN_PAGES*COLS));

  p_busy_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(col_ptr) && $stable(page_sel) &&
              $stable(contrast_lvl) && $stable(ctrl_flags)));
endmodule

bind lcd_host_ctrl lcd_host_ctrl_chk #(
  .COLS(COLS), .PAGES(PAGES), .MAIN_PAGES(MAIN_PAGES),
  .CW(CW), .PW(PW), .NFLAGS(lcdh_pkg::NFLAGS)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .mem_re(mem_re), .bus_dout(bus_dout),
  .page_sel(page_sel), .col_ptr(col_ptr), .contrast_lvl(contrast_lvl),
  .ctrl_flags(ctrl_flags)
);

// File: tb/lcd_host_ctrl_test.sv
`timescale 1ns/1ps
module lcd_host_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_stb = 1'b1, bus_dc = 1'b0, bus_rw = 1'b0;
  logic [7:0]  bus_din = 8'h00;
  logic [7:0]  bus_dout;
  logic        busy;
  logic [1:0]  page_sel;
  logic [6:0]  col_ptr;
  logic [3:0]  contrast_lvl, scroll_ofs;
  logic [1:0]  temp_coef;
  logic [2:0]  annun_on;
  logic [12:0] ctrl_flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;   // 125 MHz

  lcd_host_ctrl uut (
    .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_dc(bus_dc), .bus_rw(bus_rw),
    .bus_din(bus_din), .bus_dout(bus_dout), .busy(busy), .page_sel(page_sel),
    .col_ptr(col_ptr), .contrast_lvl(contrast_lvl), .scroll_ofs(scroll_ofs),
    .temp_coef(temp_coef), .annun_on(annun_on), .ctrl_flags(ctrl_flags)
  );

  // ---------------- behavioural reference model ----------------
  int          m_page, m_col, m_save, m_arm, m_contrast, m_scroll, m_tc, m_busy;
  logic [2:0]  m_ann;
  logic [12:0] m_flags;
  logic [7:0]  m_dout;
  logic [7:0]  mm [0:359];
  bit          hist[$];
  int          pend_due[$];
  int          pend_val[$];

  function automatic int flag_of(int code);
    case (code)
      8'h20: return 0;  8'h22: return 1;  8'h24: return 2;  8'h28: return 3;
      8'h2A: return 4;  8'h2C: return 5;  8'h2E: return 6;  8'h30: return 7;
      8'h32: return 8;  8'h3C: return 9;  8'h3E: return 10; 8'h7A: return 11;
      8'h7E: return 12;
      default: return -1;
    endcase
  endfunction

  task automatic m_cmd(int b);
    int f;
    f = flag_of(b & 8'hFE);
    if (b >= 128) begin
      if (b - 128 < 120) m_col = b - 128;
    end else if (b <= 2) m_page = b;
    else if (b >= 8'h10 && b < 8'h20) m_contrast = b - 16;
    else if (f >= 0) m_flags[f] = b[0];
    else if (b == 8'h34) m_col = m_save;
    else if (b == 8'h35) m_save = m_col;
    else if (b == 8'h36) m_arm = 1;
    else if (b == 8'h37) m_arm = 2;
    else if (b >= 8'h40 && b < 8'h50) m_scroll = b & 15;
    else if (b >= 8'h60 && b < 8'h66) m_ann[(b >> 1) & 3] = b[0];
    else if (b >= 8'h6C && b < 8'h70) m_tc = b & 3;
    else if (b == 8'h70) m_contrast = (m_contrast + 15) % 16;
    else if (b == 8'h71) m_contrast = (m_contrast + 1) % 16;
  endtask

  task automatic m_apply(int v);
    bit dc, rw;
    int b;
    dc = v[9]; rw = v[8]; b = v & 255;
    if (!dc && !rw) m_cmd(b);
    else if (dc && !rw) begin
      if (m_arm != 0) begin
        for (int a = (m_arm == 1 ? 0 : 240); a < (m_arm == 1 ? 240 : 360); a++) mm[a] = 8'h00;
        m_busy = (m_arm == 1) ? 240 : 120;
        m_arm  = 0;
      end else begin
        mm[m_page*120 + m_col] = b[7:0];
        m_col = (m_col + 1) % 120;
      end
    end else if (dc && rw) begin
      m_dout = mm[m_page*120 + m_col];
      m_col  = (m_col + 1) % 120;
    end
  endtask

  always @(posedge clk) begin
    bit busy_before;
    if (rst) begin
      m_page = 0; m_col = 0; m_save = 0; m_arm = 0; m_contrast = 0;
      m_scroll = 0; m_tc = 0; m_busy = 0; m_ann = '0; m_flags = '0; m_dout = '0;
      hist = '{1'b1, 1'b1, 1'b1};
      pend_due = {}; pend_val = {};
    end else begin
      busy_before = (m_busy > 0);
      hist.push_front(bus_stb);
      if (hist.size() > 3) void'(hist.pop_back());
      foreach (pend_due[k]) pend_due[k]--;
      if (pend_due.size() > 0 && pend_due[0] == 0) begin
        if (!busy_before) m_apply(pend_val[0]);
        void'(pend_due.pop_front());
        void'(pend_val.pop_front());
      end
      if (hist[1] == 1'b0 && hist[2] == 1'b1) begin
        pend_due.push_back(2);
        pend_val.push_back({22'd0, bus_dc, bus_rw, bus_din});
      end
      if (busy_before) m_busy--;
    end
  end

  // ---------------- checking ----------------
  task automatic expect_eq(string tag, string what, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      expect_eq("R4",  "model col_ptr",      int'(col_ptr),      m_col);
      expect_eq("R5",  "model page_sel",     int'(page_sel),     m_page);
      expect_eq("R7",  "model busy",         int'(busy),         int'(m_busy > 0));
      expect_eq("R4",  "model bus_dout",     int'(bus_dout),     int'(m_dout));
      expect_eq("R9",  "model contrast_lvl", int'(contrast_lvl), m_contrast);
      expect_eq("R10", "model ctrl_flags",   int'(ctrl_flags),   int'(m_flags));
      expect_eq("R11", "model scroll_ofs",   int'(scroll_ofs),   m_scroll);
      expect_eq("R11", "model temp_coef",    int'(temp_coef),    m_tc);
      expect_eq("R12", "model annun_on",     int'(annun_on),     int'(m_ann));
    end
  end

  int run = 0, last_run = 0;
  always @(negedge clk) begin
    if (busy) run++;
    else if (run > 0) begin last_run = run; run = 0; end
  end

  task automatic xfer(bit dc, bit rw, logic [7:0] d);
    @(negedge clk);
    bus_dc = dc; bus_rw = rw; bus_din = d; bus_stb = 1'b0;
    repeat (3) @(negedge clk);
    bus_stb = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmd(logic [7:0] d);  xfer(1'b0, 1'b0, d); endtask
  task automatic wr(logic [7:0] d);   xfer(1'b1, 1'b0, d); endtask
  task automatic rd();                xfer(1'b1, 1'b1, 8'h00); endtask
  task automatic wait_idle();         while (busy) @(negedge clk); @(negedge clk); endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", 150000, 0);
      finish_run();
    end
  end

  initial begin
    logic [7:0] snap_d;
    int snap_c, snap_f, snap_k;
    logic [7:0] rsv [18];

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    expect_eq("R1", "page", int'(page_sel), 0);
    expect_eq("R1", "col", int'(col_ptr), 0);
    expect_eq("R1", "flags", int'(ctrl_flags), 0);
    expect_eq("R1", "contrast", int'(contrast_lvl), 0);
    expect_eq("R1", "busy", int'(busy), 0);
    expect_eq("R1", "dout", int'(bus_dout), 0);
    expect_eq("R1", "annun", int'(annun_on), 0);

    // R7 clears of both regions, busy lengths
    cmd(8'h36); wr(8'hAA);
    expect_eq("R7", "busy after dummy", int'(busy), 1);
    expect_eq("R7", "col after dummy", int'(col_ptr), 0);
    wait_idle();
    expect_eq("R7", "main clear length", last_run, 240);
    cmd(8'h37); wr(8'hAA); wait_idle();
    expect_eq("R7", "icon clear length", last_run, 120);

    // R4 writes, wrap
    cmd(8'h85); wr(8'h11); wr(8'h22);
    expect_eq("R4", "col after 2 writes", int'(col_ptr), 7);
    cmd(8'h01); cmd(8'hF7); wr(8'h33);
    expect_eq("R4", "col wrap", int'(col_ptr), 0);
    expect_eq("R4", "page kept", int'(page_sel), 1);
    cmd(8'h02); wr(8'h44);
    expect_eq("R5", "page 2", int'(page_sel), 2);
    cmd(8'h00); cmd(8'h85); rd();
    expect_eq("R4", "read data", int'(bus_dout), 8'h11);
    expect_eq("R4", "col after read", int'(col_ptr), 6);
    rd();
    expect_eq("R4", "read data 2", int'(bus_dout), 8'h22);
    cmd(8'h01); cmd(8'hF7); rd();
    expect_eq("R4", "read page1 col119", int'(bus_dout), 8'h33);
    cmd(8'h00); cmd(8'h87);

    // R2 invalid pair
    xfer(1'b0, 1'b1, 8'h85);
    expect_eq("R2", "invalid col", int'(col_ptr), 7);
    expect_eq("R2", "invalid dout", int'(bus_dout), 8'h33);

    // R3 column range
    cmd(8'hF8);
    expect_eq("R3", "col 120 ignored", int'(col_ptr), 7);
    cmd(8'hFF);
    expect_eq("R3", "col 127 ignored", int'(col_ptr), 7);
    cmd(8'hF7);
    expect_eq("R3", "col 119", int'(col_ptr), 119);

    // R5 page 3 ignored
    cmd(8'h03);
    expect_eq("R5", "page 3 ignored", int'(page_sel), 0);

    // R6 save/restore
    cmd(8'h8A); cmd(8'h35); cmd(8'hB2); wr(8'h55);
    expect_eq("R6", "col before restore", int'(col_ptr), 51);
    cmd(8'h34);
    expect_eq("R6", "restored col", int'(col_ptr), 10);

    // R7/R8 clear with read while armed, command during busy
    cmd(8'h36); cmd(8'h85); rd();
    expect_eq("R7", "read while armed", int'(bus_dout), 8'h11);
    wr(8'h99);
    expect_eq("R7", "dummy col", int'(col_ptr), 6);
    cmd(8'h81); cmd(8'h1F);
    wait_idle();
    expect_eq("R8", "col held during busy", int'(col_ptr), 6);
    expect_eq("R8", "contrast held during busy", int'(contrast_lvl), 0);
    cmd(8'h02); cmd(8'h80); rd();
    expect_eq("R7", "icon page kept", int'(bus_dout), 8'h44);
    cmd(8'h00); cmd(8'h85); rd();
    expect_eq("R7", "main cleared", int'(bus_dout), 8'h00);
    cmd(8'h01); cmd(8'hF7); rd();
    expect_eq("R7", "page1 cleared", int'(bus_dout), 8'h00);
    cmd(8'h00); cmd(8'h85); wr(8'h77);
    expect_eq("R7", "arm consumed col", int'(col_ptr), 6);
    cmd(8'h85); rd();
    expect_eq("R7", "arm consumed data", int'(bus_dout), 8'h77);

    // R9 contrast
    cmd(8'h1F);
    expect_eq("R9", "load 15", int'(contrast_lvl), 15);
    cmd(8'h71);
    expect_eq("R9", "inc wrap", int'(contrast_lvl), 0);
    cmd(8'h70);
    expect_eq("R9", "dec wrap", int'(contrast_lvl), 15);
    cmd(8'h13);
    expect_eq("R9", "load 3", int'(contrast_lvl), 3);

    // R10 every enable bit
    for (int i = 0; i < 256; i += 2) begin
      int f;
      f = flag_of(i);
      if (f >= 0) begin
        cmd(8'(i + 1));
        expect_eq("R10", $sformatf("set bit %0d", f), int'(ctrl_flags), 1 << f);
        cmd(8'(i));
        expect_eq("R10", $sformatf("clear bit %0d", f), int'(ctrl_flags), 0);
      end
    end

    // R11 scroll and temperature coefficient
    cmd(8'h4A);
    expect_eq("R11", "scroll", int'(scroll_ofs), 10);
    cmd(8'h6E);
    expect_eq("R11", "tcoef", int'(temp_coef), 2);

    // R12 annunciators
    cmd(8'h63);
    expect_eq("R12", "annun 1 on", int'(annun_on), 3'b010);
    cmd(8'h65);
    expect_eq("R12", "annun 2 on", int'(annun_on), 3'b110);
    cmd(8'h67);
    expect_eq("R12", "index 3 ignored", int'(annun_on), 3'b110);
    cmd(8'h62);
    expect_eq("R12", "annun 1 off", int'(annun_on), 3'b100);

    // R13 reserved codes
    cmd(8'h29); cmd(8'h8C);
    rsv = '{8'h03, 8'h26, 8'h27, 8'h38, 8'h39, 8'h3A, 8'h3B, 8'h50, 8'h5F,
            8'h68, 8'h69, 8'h6B, 8'h72, 8'h76, 8'h77, 8'h79, 8'h7C, 8'h7D};
    snap_d = bus_dout; snap_c = int'(col_ptr); snap_f = int'(ctrl_flags);
    snap_k = int'(contrast_lvl);
    foreach (rsv[k]) cmd(rsv[k]);
    expect_eq("R13", "col", int'(col_ptr), snap_c);
    expect_eq("R13", "flags", int'(ctrl_flags), snap_f);
    expect_eq("R13", "contrast", int'(contrast_lvl), snap_k);
    expect_eq("R13", "dout", int'(bus_dout), int'(snap_d));
    expect_eq("R13", "page", int'(page_sel), 0);
    expect_eq("R13", "scroll", int'(scroll_ofs), 10);
    expect_eq("R13", "tcoef", int'(temp_coef), 2);
    expect_eq("R13", "annun", int'(annun_on), 3'b100);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule